// File: doc/BRIEF.md
# Interrupt Priority and Status-Word Swap

This block takes pending interruption requests from five classes (machine check, program, supervisor call, external and I/O) and gates each one with the enable bits held in the current 64-bit program status word. It then selects the most urgent enabled class. At an instruction boundary the CPU core signals that it can be interrupted. The block then records the current status word, with an interruption code and instruction length code filled in, into that class's fixed "old" doubleword in memory. It then fetches the class's "new" doubleword and installs it as the current status word. Servicing therefore works by exchanging whole status words, not by jumping to a vector.

Status-word bits are numbered with bit 0 as the most significant, so PSW bit n is vector index 63-n. The upper memory word holds bits 0-31. The core may overwrite the status word while the block is idle. Memory is reached through a 32-bit request/acknowledge port with byte addresses.

Top module: `irq_status_swap`

## Requirements
- R1: After reset the current status word equals parameter RESET_PSW (default zero), and busy, memReq, swapDone and intPending are all low.
- R2: When several enabled classes are pending, the block services them in this order: machine check, program, supervisor call, external, I/O. Program and supervisor call share a priority level, and program goes first when both are pending.
- R3: Machine check is enabled by bit 13 and external by bit 7. An I/O request for channel c (ioDevAddr[15:8]) is enabled by bit c when c<6, and by bit 6 otherwise. Program and supervisor call are never masked. A masked request stays pending without starting a swap, and is serviced once the bit is set.
- R4: A program request whose exception code is 0x08, 0x0A, 0x0D or 0x0E is discarded at arrival when status-word bit 36, 37, 38 or 39 respectively is zero. All other codes are always accepted.
- R5: Old/new doubleword byte addresses are: external 0x18/0x58, supervisor call 0x20/0x60, program 0x28/0x68, machine check 0x30/0x70, I/O 0x38/0x78.
- R6: A swap makes exactly four transactions in order: write old upper word at old address, write old lower word at old+4, read new address, read new+4. Each request is held with a stable address until memAck. busy is high for the whole swap.
- R7: The stored old word equals the current status word, except bits 16-31 (interruption code) and bits 32-33 (length code). The code is: 0 for machine check; the 8-bit exception code zero-extended for program; the 8-bit call number for supervisor call; for external, a low byte holding the accumulated sources (extReq[7] timer = bit 24, extReq[6] interrupt key, extReq[5:0] signals 2-7) with the upper byte zero; the 16-bit device address for I/O. The length code is pgmIlc/svcIlc for program/supervisor call and 0 otherwise.
- R8: After the last read the new doubleword becomes the current status word, and swapDone pulses for one cycle. Only the serviced class's pending state is cleared.
- R9: A swap starts only on a cycle where atBoundary is high and an enabled request is pending (intPending). pswWr takes effect only when idle and no swap is starting.
- R10: External source bits accumulate by OR until an external swap completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| atBoundary | input | 1 | Core is between instructions and can be interrupted |
| pswWr | input | 1 | Core writes the status word |
| pswWrData | input | 64 | Status word written by the core |
| curPsw | output | 64 | Current status word |
| mchkReq | input | 1 | Machine-check request pulse |
| pgmReq | input | 1 | Program exception request pulse |
| pgmCode | input | 8 | Program exception code |
| pgmIlc | input | 2 | Length code of the failing instruction |
| svcReq | input | 1 | Supervisor-call request pulse |
| svcNum | input | 8 | Supervisor-call number |
| svcIlc | input | 2 | Length code of the call instruction |
| extReq | input | 8 | External source pulses (bit 7 timer) |
| ioReq | input | 1 | I/O request pulse |
| ioDevAddr | input | 16 | Channel (high byte) and device address |
| intPending | output | 1 | An enabled request is pending |
| busy | output | 1 | Swap in progress |
| swapDone | output | 1 | One-cycle pulse after new word is installed |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 24 | Byte address |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Transaction completes |
| memRdata | input | 32 | Read data, valid with memAck |

## Verification
The checks that run every cycle cover the shape of the memory traffic: writes only to old slots, reads only to new slots, and requests held steady until acknowledged. They also cover the status word staying frozen through a swap, swaps starting only from an enabled request at a boundary, and a masked I/O request never being dropped. The bench scenarios cover the values: which class wins under each mask combination, the exact interruption and length codes in the stored old word, discarded program exceptions, and the accumulation of external sources. They also check that a swap leaves the other pending classes untouched for later rounds.

// File: rtl/irq_swap_pkg.sv
`timescale 1ns/1ps
package irq_swap_pkg;
  localparam int PSW_W  = 64;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    CLS_MCHK = 3'd0,
    CLS_PGM  = 3'd1,
    CLS_SVC  = 3'd2,
    CLS_EXT  = 3'd3,
    CLS_IO   = 3'd4,
    CLS_NONE = 3'd7
  } irqClass_e;

  localparam int NUM_CLS = 5;

  typedef enum logic [1:0] {
    PH_WR_HI = 2'd0,
    PH_WR_LO = 2'd1,
    PH_RD_HI = 2'd2,
    PH_RD_LO = 2'd3
  } swapPhase_e;

  typedef struct packed {
    logic       idle;
    logic       start;
    logic       latchHi;
    logic       loadNew;
    swapPhase_e phase;
  } swapStrobe_t;

  // Vector index of status-word bit n (bit 0 is the most significant).
  function automatic int pb(input int n);
    return PSW_W - 1 - n;
  endfunction

  function automatic logic [7:0] oldSlot(input irqClass_e c);
    case (c)
      CLS_EXT:  return 8'h18;
      CLS_SVC:  return 8'h20;
      CLS_PGM:  return 8'h28;
      CLS_MCHK: return 8'h30;
      CLS_IO:   return 8'h38;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] newSlot(input irqClass_e c);
    return oldSlot(c) + 8'h40;
  endfunction
endpackage

// File: rtl/irq_swap_arb.sv
`timescale 1ns/1ps
module irq_swap_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] enabled,
  output logic [N-1:0] grantOh,
  output logic         anyEnabled
);
  logic [N:0] higher;
  assign higher[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign higher[i+1] = higher[i] | enabled[i];
    assign grantOh[i]  = enabled[i] & ~higher[i];
  end

  assign anyEnabled = higher[N];
endmodule

// File: rtl/irq_swap_ctrl.sv
`timescale 1ns/1ps
module irq_swap_ctrl
  import irq_swap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        atBoundary,
  input  logic        anyEnabled,
  input  logic        memAck,
  output swapStrobe_t strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        busy,
  output logic        swapDone
);
  logic       active;
  swapPhase_e phase;
  logic       startNow;
  logic       lastAck;

  assign startNow = !active && atBoundary && anyEnabled;
  assign lastAck  = active && memAck && (phase == PH_RD_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      phase    <= PH_WR_HI;
      swapDone <= 1'b0;
    end else begin
      swapDone <= lastAck;
      if (startNow) begin
        active <= 1'b1;
        phase  <= PH_WR_HI;
      end else if (active && memAck) begin
        if (phase == PH_RD_LO) active <= 1'b0;
        else phase <= swapPhase_e'(phase + 2'd1);
      end
    end
  end

  assign memReq = active;
  assign memWe  = active && (phase == PH_WR_HI || phase == PH_WR_LO);
  assign busy   = active;

  always_comb begin
    strobe.idle    = !active;
    strobe.start   = startNow;
    strobe.latchHi = active && memAck && (phase == PH_RD_HI);
    strobe.loadNew = lastAck;
    strobe.phase   = phase;
  end

  assert_done_follows_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    swapDone |-> $past(busy));
endmodule

// File: rtl/irq_swap_path.sv
`timescale 1ns/1ps
module irq_swap_path
  import irq_swap_pkg::*;
#(
  parameter logic [PSW_W-1:0] RESET_PSW = '0,
  parameter int               ADDR_W    = 24,
  parameter int               CH_DIRECT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapStrobe_t       strobe,
  input  logic              pswWr,
  input  logic [PSW_W-1:0]  pswWrData,
  input  logic              mchkReq,
  input  logic              pgmReq,
  input  logic [7:0]        pgmCode,
  input  logic [1:0]        pgmIlc,
  input  logic              svcReq,
  input  logic [7:0]        svcNum,
  input  logic [1:0]        svcIlc,
  input  logic [7:0]        extReq,
  input  logic              ioReq,
  input  logic [15:0]       ioDevAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic [PSW_W-1:0]  curPsw,
  output logic              anyEnabled,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);
  localparam int IC_HI  = pb(16);
  localparam int IC_LO  = pb(31);
  localparam int ILC_HI = pb(32);
  localparam int ILC_LO = pb(33);

  logic              mchkPend, pgmPend, svcPend, ioPend;
  logic [7:0]        pgmCodeR, svcNumR, extPend;
  logic [1:0]        pgmIlcR, svcIlcR;
  logic [15:0]       ioDevR;
  logic [PSW_W-1:0]  psw, oldWord;
  logic [WORD_W-1:0] newHi;
  irqClass_e         servCls, winCls;
  logic [NUM_CLS-1:0] enabled, grantOh;
  logic              ioEn, pgmOk;
  logic [15:0]       winCode;
  logic [1:0]        winIlc;

  // Program-mask filter on arrival.
  always_comb begin
    case (pgmCode)
      8'h08:   pgmOk = psw[pb(36)];
      8'h0A:   pgmOk = psw[pb(37)];
      8'h0D:   pgmOk = psw[pb(38)];
      8'h0E:   pgmOk = psw[pb(39)];
      default: pgmOk = 1'b1;
    endcase
  end

  // Channel mask: direct bit for low channels, shared bit above.
  always_comb begin
    int ch;
    ch = int'(ioDevR[15:8]);
    if (ch < CH_DIRECT) ioEn = psw[PSW_W-1-ch];
    else                ioEn = psw[PSW_W-1-CH_DIRECT];
  end

  always_comb begin
    enabled = '0;
    enabled[CLS_MCHK] = mchkPend && psw[pb(13)];
    enabled[CLS_PGM]  = pgmPend;
    enabled[CLS_SVC]  = svcPend;
    enabled[CLS_EXT]  = (|extPend) && psw[pb(7)];
    enabled[CLS_IO]   = ioPend && ioEn;
  end

  irq_swap_arb #(.N(NUM_CLS)) u_arb (
    .enabled   (enabled),
    .grantOh   (grantOh),
    .anyEnabled(anyEnabled)
  );

  always_comb begin
    winCls = CLS_NONE;
    for (int i = NUM_CLS - 1; i >= 0; i--)
      if (grantOh[i]) winCls = irqClass_e'(i);
  end

  always_comb begin
    winCode = 16'h0000;
    winIlc  = 2'b00;
    case (winCls)
      CLS_PGM: begin winCode = {8'h00, pgmCodeR}; winIlc = pgmIlcR; end
      CLS_SVC: begin winCode = {8'h00, svcNumR};  winIlc = svcIlcR; end
      CLS_EXT: winCode = {8'h00, extPend};
      CLS_IO:  winCode = ioDevR;
      default: ;
    endcase
  end

  logic clrM, clrP, clrS, clrE, clrI;
  assign clrM = strobe.loadNew && servCls == CLS_MCHK;
  assign clrP = strobe.loadNew && servCls == CLS_PGM;
  assign clrS = strobe.loadNew && servCls == CLS_SVC;
  assign clrE = strobe.loadNew && servCls == CLS_EXT;
  assign clrI = strobe.loadNew && servCls == CLS_IO;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mchkPend <= 1'b0;
      pgmPend  <= 1'b0;
      svcPend  <= 1'b0;
      ioPend   <= 1'b0;
      extPend  <= '0;
      pgmCodeR <= '0;
      pgmIlcR  <= '0;
      svcNumR  <= '0;
      svcIlcR  <= '0;
      ioDevR   <= '0;
    end else begin
      mchkPend <= mchkReq | (mchkPend & ~clrM);
      extPend  <= (clrE ? 8'h00 : extPend) | extReq;

      if (clrP) pgmPend <= 1'b0;
      if (pgmReq && pgmOk && (!pgmPend || clrP)) begin
        pgmPend  <= 1'b1;
        pgmCodeR <= pgmCode;
        pgmIlcR  <= pgmIlc;
      end

      if (clrS) svcPend <= 1'b0;
      if (svcReq && (!svcPend || clrS)) begin
        svcPend <= 1'b1;
        svcNumR <= svcNum;
        svcIlcR <= svcIlc;
      end

      if (clrI) ioPend <= 1'b0;
      if (ioReq && (!ioPend || clrI)) begin
        ioPend <= 1'b1;
        ioDevR <= ioDevAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psw     <= RESET_PSW;
      oldWord <= '0;
      newHi   <= '0;
      servCls <= CLS_NONE;
    end else begin
      if (strobe.start) begin
        servCls <= winCls;
        oldWord <= psw;
        oldWord[IC_HI:IC_LO]   <= winCode;
        oldWord[ILC_HI:ILC_LO] <= winIlc;
      end
      if (strobe.latchHi) newHi <= memRdata;
      if (strobe.loadNew) psw <= {newHi, memRdata};
      else if (pswWr && strobe.idle && !strobe.start) psw <= pswWrData;
    end
  end

  always_comb begin
    logic [7:0] slot;
    case (strobe.phase)
      PH_WR_HI: slot = oldSlot(servCls);
      PH_WR_LO: slot = oldSlot(servCls) + 8'h04;
      PH_RD_HI: slot = newSlot(servCls);
      default:  slot = newSlot(servCls) + 8'h04;
    endcase
    memAddr  = ADDR_W'(slot);
    memWdata = (strobe.phase == PH_WR_HI) ? oldWord[PSW_W-1:WORD_W] :
               (strobe.phase == PH_WR_LO) ? oldWord[WORD_W-1:0] : '0;
  end

  assign curPsw = psw;

  assert_masked_io_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ioPend && !enabled[CLS_IO]) |=> ioPend);
endmodule

// File: rtl/irq_status_swap.sv
`timescale 1ns/1ps
module irq_status_swap
  import irq_swap_pkg::*;
#(
  parameter logic [63:0] RESET_PSW = 64'h0,
  parameter int          ADDR_W    = 24,
  parameter int          CH_DIRECT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              atBoundary,
  input  logic              pswWr,
  input  logic [63:0]       pswWrData,
  output logic [63:0]       curPsw,
  input  logic              mchkReq,
  input  logic              pgmReq,
  input  logic [7:0]        pgmCode,
  input  logic [1:0]        pgmIlc,
  input  logic              svcReq,
  input  logic [7:0]        svcNum,
  input  logic [1:0]        svcIlc,
  input  logic [7:0]        extReq,
  input  logic              ioReq,
  input  logic [15:0]       ioDevAddr,
  output logic              intPending,
  output logic              busy,
  output logic              swapDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata
);
  swapStrobe_t strobe;
  logic        anyEnabled;

  irq_swap_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .atBoundary(atBoundary),
    .anyEnabled(anyEnabled),
    .memAck    (memAck),
    .strobe    (strobe),
    .memReq    (memReq),
    .memWe     (memWe),
    .busy      (busy),
    .swapDone  (swapDone)
  );

  irq_swap_path #(
    .RESET_PSW(RESET_PSW),
    .ADDR_W   (ADDR_W),
    .CH_DIRECT(CH_DIRECT)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pswWr     (pswWr),
    .pswWrData (pswWrData),
    .mchkReq   (mchkReq),
    .pgmReq    (pgmReq),
    .pgmCode   (pgmCode),
    .pgmIlc    (pgmIlc),
    .svcReq    (svcReq),
    .svcNum    (svcNum),
    .svcIlc    (svcIlc),
    .extReq    (extReq),
    .ioReq     (ioReq),
    .ioDevAddr (ioDevAddr),
    .memRdata  (memRdata),
    .curPsw    (curPsw),
    .anyEnabled(anyEnabled),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  assign intPending = anyEnabled && !busy;

  assert_write_old_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memAddr >= ADDR_W'(8'h18) && memAddr < ADDR_W'(8'h40)));

  assert_read_new_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> (memAddr >= ADDR_W'(8'h58) && memAddr < ADDR_W'(8'h80)));

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_psw_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curPsw));

  assert_start_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(atBoundary) && $past(anyEnabled)));
endmodule

// File: tb/irq_status_swap_test.sv
`timescale 1ns/1ps
module irq_status_swap_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        atBoundary = 0, pswWr = 0;
  logic [63:0] pswWrData = '0;
  logic [63:0] curPsw;
  logic        mchkReq = 0, pgmReq = 0, svcReq = 0, ioReq = 0;
  logic [7:0]  pgmCode = 0, svcNum = 0, extReq = 0;
  logic [1:0]  pgmIlc = 0, svcIlc = 0;
  logic [15:0] ioDevAddr = 0;
  logic        intPending, busy, swapDone, memReq, memWe;
  logic [23:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic        memAck;

  always #2.5 clk = ~clk;

  irq_status_swap uut (
    .clk(clk), .rstN(rstN), .atBoundary(atBoundary), .pswWr(pswWr),
    .pswWrData(pswWrData), .curPsw(curPsw), .mchkReq(mchkReq),
    .pgmReq(pgmReq), .pgmCode(pgmCode), .pgmIlc(pgmIlc), .svcReq(svcReq),
    .svcNum(svcNum), .svcIlc(svcIlc), .extReq(extReq), .ioReq(ioReq),
    .ioDevAddr(ioDevAddr), .intPending(intPending), .busy(busy),
    .swapDone(swapDone), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [0:31];
  logic [23:0] logAddr [0:7];
  logic        logWe [0:7];
  int          logN = 0;

  // Memory responder: acknowledges one cycle after a request appears.
  always @(negedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; memRdata <= '0;
    end else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (logN < 8) begin logAddr[logN] = memAddr; logWe[logN] = memWe; end
      logN++;
      if (memWe) mem[memAddr[6:2]] = memWdata;
      else memRdata <= mem[memAddr[6:2]];
    end else memAck <= 1'b0;
  end

  localparam logic [63:0] ALL_EN = 64'hFF04_0000_0F00_0000;

  // Bench model of pending state.
  logic [63:0] expPsw;
  logic mM, mP, mS, mI;
  logic [7:0] mPc, mSn, mE;
  logic [1:0] mPi, mSi;
  logic [15:0] mDev;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] slotOf(input int c);
    case (c)
      0: return 8'h30; 1: return 8'h28; 2: return 8'h20;
      3: return 8'h18; default: return 8'h38;
    endcase
  endfunction

  function automatic bit bitOf(input logic [63:0] p, input int n);
    return p[63-n];
  endfunction

  function automatic bit pgmAccepted(input logic [7:0] c, input logic [63:0] p);
    if (c == 8'h08) return bitOf(p, 36);
    if (c == 8'h0A) return bitOf(p, 37);
    if (c == 8'h0D) return bitOf(p, 38);
    if (c == 8'h0E) return bitOf(p, 39);
    return 1'b1;
  endfunction

  function automatic int predict();
    int ch;
    ch = int'(mDev[15:8]);
    if (mM && bitOf(expPsw, 13)) return 0;
    if (mP) return 1;
    if (mS) return 2;
    if (mE != 0 && bitOf(expPsw, 7)) return 3;
    if (mI && bitOf(expPsw, ch < 6 ? ch : 6)) return 4;
    return 7;
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic setPsw(input logic [63:0] v);
    pswWr = 1; pswWrData = v; cyc(); pswWr = 0;
    expPsw = v;
  endtask

  task automatic post(input bit mc, input bit pg, input logic [7:0] pc, input logic [1:0] pi,
                      input bit sv, input logic [7:0] sn, input logic [1:0] si,
                      input logic [7:0] ex, input bit io, input logic [15:0] dv);
    mchkReq = mc; pgmReq = pg; pgmCode = pc; pgmIlc = pi; svcReq = sv; svcNum = sn;
    svcIlc = si; extReq = ex; ioReq = io; ioDevAddr = dv;
    cyc();
    mchkReq = 0; pgmReq = 0; svcReq = 0; extReq = 0; ioReq = 0;
    if (mc) mM = 1;
    if (pg && !mP && pgmAccepted(pc, expPsw)) begin mP = 1; mPc = pc; mPi = pi; end
    if (sv && !mS) begin mS = 1; mSn = sn; mSi = si; end
    mE = mE | ex;
    if (io && !mI) begin mI = 1; mDev = dv; end
  endtask

  task automatic preload();
    for (int c = 0; c < 5; c++) begin
      mem[(slotOf(c) + 8'h40) >> 2]       = $urandom;
      mem[((slotOf(c) + 8'h40) >> 2) + 1] = $urandom;
    end
  endtask

  task automatic trySwap(input string tag);
    int c, w;
    logic [63:0] expOld, expNew, gotOld;
    logic [15:0] code;
    logic [1:0] ilc;
    c = predict();
    chk(intPending == (c != 7), {tag, " R3 intPending"}, 64'(intPending), 64'(c != 7));
    logN = 0;
    atBoundary = 1; cyc(); atBoundary = 0;
    if (c == 7) begin
      cyc(); cyc(); cyc();
      chk(!busy && logN == 0, {tag, " R9 no swap"}, 64'(logN), 64'd0);
      chk(curPsw == expPsw, {tag, " R9 psw kept"}, curPsw, expPsw);
      return;
    end
    w = 0;
    while (!swapDone && w < 60) begin cyc(); w++; end
    chk(swapDone, {tag, " R8 done"}, 64'(swapDone), 64'd1);
    code = 16'h0; ilc = 2'b00;
    case (c)
      1: begin code = {8'h00, mPc}; ilc = mPi; end
      2: begin code = {8'h00, mSn}; ilc = mSi; end
      3: code = {8'h00, mE};
      4: code = mDev;
      default: ;
    endcase
    expOld = expPsw; expOld[47:32] = code; expOld[31:30] = ilc;
    gotOld = {mem[slotOf(c) >> 2], mem[(slotOf(c) >> 2) + 1]};
    chk(gotOld == expOld, {tag, " R7 old word"}, gotOld, expOld);
    expNew = {mem[(slotOf(c) + 8'h40) >> 2], mem[((slotOf(c) + 8'h40) >> 2) + 1]};
    chk(curPsw == expNew, {tag, " R8 new word"}, curPsw, expNew);
    chk(logN == 4 && logAddr[0] == 24'(slotOf(c)) && logAddr[1] == 24'(slotOf(c) + 8'h04) &&
        logAddr[2] == 24'(slotOf(c) + 8'h40) && logAddr[3] == 24'(slotOf(c) + 8'h44) &&
        logWe[0] && logWe[1] && !logWe[2] && !logWe[3],
        {tag, " R5 R6 sequence"}, {40'(logN), logAddr[0]}, {40'd4, 24'(slotOf(c))});
    cyc();
    chk(!swapDone && !busy, {tag, " R8 pulse"}, 64'(swapDone), 64'd0);
    expPsw = expNew;
    case (c)
      0: mM = 0; 1: mP = 0; 2: mS = 0; 3: mE = 0; default: mI = 0;
    endcase
  endtask

  task automatic expectCls(input int c, input string tag);
    chk(predict() == c, {tag, " R2 class"}, 64'(predict()), 64'(c));
  endtask

  initial begin
    void'($urandom(32'h5eed));
    mM = 0; mP = 0; mS = 0; mI = 0; mPc = 0; mSn = 0; mE = 0; mPi = 0; mSi = 0; mDev = 0;
    expPsw = 64'h0;
    for (int i = 0; i < 32; i++) mem[i] = 32'h0;
    repeat (3) cyc();
    rstN = 1; cyc();
    // R1 reset state
    chk(curPsw == 64'h0 && !busy && !memReq && !swapDone && !intPending, "R1 reset",
        curPsw, 64'h0);

    // R2 program beats supervisor call, then call follows
    preload(); setPsw(ALL_EN | 64'h0000_0000_0000_1234);
    post(0, 1, 8'h05, 2'd2, 1, 8'h21, 2'd1, 8'h00, 0, 16'h0);
    expectCls(1, "pgm-svc"); trySwap("R2 pgm first");
    setPsw(ALL_EN); expectCls(2, "svc next"); trySwap("R2 svc next");

    // R3 machine check masked then enabled
    preload(); setPsw(ALL_EN & ~(64'h1 << (63 - 13)));
    post(1, 0, 0, 0, 0, 0, 0, 8'h00, 0, 16'h0);
    trySwap("R3 mchk masked");
    setPsw(ALL_EN); trySwap("R3 mchk enabled");

    // R10 external accumulation: timer then signal 7
    preload(); setPsw(ALL_EN & ~(64'h1 << (63 - 7)));
    post(0, 0, 0, 0, 0, 0, 0, 8'h80, 0, 16'h0);
    post(0, 0, 0, 0, 0, 0, 0, 8'h01, 0, 16'h0);
    trySwap("R10 ext masked");
    setPsw(ALL_EN); trySwap("R10 ext 0x81");

    // R3 I/O channel masks
    preload(); setPsw(64'h0200_0000_0000_0000);
    post(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 16'h0712);
    trySwap("R3 io ch7 via bit6");
    setPsw(64'h0200_0000_0000_0000);
    post(0, 0, 0, 0, 0, 0, 0, 8'h00, 1, 16'h0503);
    trySwap("R3 io ch5 masked");
    setPsw(64'h0400_0000_0000_0000); trySwap("R3 io ch5 enabled");

    // R4 masked fixed-point overflow discarded, then accepted
    preload(); setPsw(ALL_EN & ~(64'h1 << (63 - 36)));
    post(0, 1, 8'h08, 2'd2, 0, 0, 0, 8'h00, 0, 16'h0);
    setPsw(ALL_EN); trySwap("R4 dropped");
    post(0, 1, 8'h08, 2'd2, 0, 0, 0, 8'h00, 0, 16'h0);
    trySwap("R4 accepted");

    // R2 all classes at once
    preload(); setPsw(ALL_EN);
    post(1, 1, 8'h0E, 2'd3, 1, 8'h99, 2'd2, 8'h40, 1, 16'h0001);
    for (int k = 0; k < 5; k++) begin
      setPsw(ALL_EN | 64'(k)); expectCls(k, "all"); trySwap("R2 all");
    end

    // Random rounds
    for (int r = 0; r < 150; r++) begin
      logic [63:0] p;
      preload();
      p = {$urandom, $urandom};
      setPsw(p);
      post(($urandom % 6) == 0, ($urandom % 3) == 0, 8'($urandom % 16), 2'($urandom),
           ($urandom % 3) == 0, 8'($urandom), 2'($urandom),
           (($urandom % 3) == 0) ? 8'($urandom) : 8'h00,
           ($urandom % 3) == 0, {8'($urandom % 10), 8'($urandom)});
      trySwap("R7 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule